// File: doc/BRIEF.md
# Per-Block Lock Protection Manager

This block holds a two-bit protection state for every erase block of one flash bank and decides, with no added cycles, whether a program or erase aimed at a block may proceed. Lock, unlock and lock-down requests arrive from the command decoder as a stream of byte-wide command beats, each carrying a block index. A request takes two beats: a setup beat, then a confirm beat that selects the action and the block.

Protection has two levels. A locked block refuses program and erase, but an unlock can release it. A locked-down block also carries a mark that only reset clears. While the active-low write-protect pin is low, that mark makes unlock requests to the block fail. While the pin is high, the mark is ignored and the block can be locked and unlocked freely. When the pin goes low again, the mark takes effect again.

The status logic asks about one block through a check port and gets a permit flag and a lock-error flag. Identifier-mode reads get a block's two status bits through a separate read port.

Top module: `blkprot_mgr`

## Requirements
- R1: During and after reset, every block reads status `01` (bit 0 = locked, bit 1 = lock-down mark), so permit is 0 for every block.
- R2: A setup beat (code 0x60) followed by a confirm beat acts on the block index of the confirm beat. Code 0x01 sets locked, 0x2F sets locked and the lock-down mark, and 0xD0 clears locked. The new status is visible on the read and check ports in the cycle after the clock edge that accepts the confirm beat.
- R3: A confirm code only acts if the last accepted beat before it was a setup beat. Cycles with `cmd_valid` low do not disarm the setup. Any other code after a setup cancels it. A second setup beat keeps the sequence armed.
- R4: While `wp_n` is 0, an unlock sent to a block that has the lock-down mark is refused, and the block keeps status `11`.
- R5: While `wp_n` is 1, an unlock sent to a block with the lock-down mark clears bit 0 and keeps bit 1 (status `10`), and a lock sets status `11` again.
- R6: After `wp_n` returns to 0, a block that still has the mark and is locked again refuses a later unlock.
- R7: Lock and unlock commands never clear the lock-down mark. Only reset clears it.
- R8: `chk_permit` is the inverse of bit 0 of the addressed block, with no cycle of delay. `chk_lock_err` is 1 exactly when `chk_valid` is 1 and permit is 0.
- R9: A block index of `NUM_BLK` or above changes no block. On the read ports such an index reads as status `01` with permit 0.
- R10: `cmd_ready` is always 1. Every beat that has `cmd_valid` high is consumed in its own cycle, and the decoder never sees back-pressure.
- R11: A command changes only the block it names. All other blocks keep their status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin; low enforces the lock-down mark |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Beat accepted (always 1) |
| cmd_code | input | 8 | Command byte |
| cmd_blk | input | BW | Block index of the beat |
| chk_valid | input | 1 | A program or erase is being qualified |
| chk_blk | input | BW | Block targeted by the program or erase |
| chk_permit | output | 1 | Block is unlocked |
| chk_lock_err | output | 1 | Qualified operation hits a locked block |
| stat_blk | input | BW | Block for an identifier-mode status read |
| stat_bits | output | 2 | Bit 1 lock-down mark, bit 0 locked |

## Verification
The bench builds the block with `NUM_BLK` = 6. With six blocks the index is three bits wide, so indices 6 and 7 can be driven, and the out-of-range handling of both commands and reads gets exercised. The bench compares all six blocks against a model after every scenario, so a command that writes to the wrong block or to two blocks is caught.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  localparam logic [7:0] CODE_SETUP  = 8'h60;
  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_DOWN   = 8'h2F;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_DOWN   = 2'd2,
    OP_UNLOCK = 2'd3
  } lk_op_e;
endpackage

// File: rtl/blkprot_seq.sv
module blkprot_seq
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic [BW-1:0] cmd_blk,
  output logic          go,
  output lk_op_e        op,
  output logic [BW-1:0] blk
);
  logic   armed_q;
  lk_op_e dec_op;
  logic   in_range;

  always_comb begin
    unique case (cmd_code)
      CODE_LOCK:   dec_op = OP_LOCK;
      CODE_DOWN:   dec_op = OP_DOWN;
      CODE_UNLOCK: dec_op = OP_UNLOCK;
      default:     dec_op = OP_NONE;
    endcase
  end

  assign in_range = (32'(cmd_blk) < NUM_BLK);
  assign go  = cmd_valid && armed_q && (dec_op != OP_NONE) && in_range;
  assign op  = go ? dec_op : OP_NONE;
  assign blk = cmd_blk;

  always_ff @(posedge clk) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else if (cmd_valid)
      armed_q <= (cmd_code == CODE_SETUP);
  end
endmodule

// File: rtl/blkprot_cell.sv
module blkprot_cell
  import blkprot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wp_n,
  input  logic   hit,
  input  lk_op_e op,
  output logic   locked,
  output logic   down
);
  logic unlock_ok;
  assign unlock_ok = !(down && !wp_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
      down   <= 1'b0;
    end else if (hit) begin
      unique case (op)
        OP_LOCK:   locked <= 1'b1;
        OP_DOWN: begin
          locked <= 1'b1;
          down   <= 1'b1;
        end
        OP_UNLOCK: if (unlock_ok) locked <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blkprot_port.sv
module blkprot_port #(
  parameter int NUM_BLK = 16,
  parameter int BW = 4
) (
  input  logic [NUM_BLK-1:0] lk,
  input  logic [NUM_BLK-1:0] dn,
  input  logic [BW-1:0]      idx,
  output logic [1:0]         bits
);
  always_comb begin
    bits = 2'b01;
    for (int i = 0; i < NUM_BLK; i++)
      if (idx == BW'(i)) bits = {dn[i], lk[i]};
  end
endmodule

// File: rtl/blkprot_mgr.sv
module blkprot_mgr
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 16,
  localparam int BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_code,
  input  logic [BW-1:0] cmd_blk,
  input  logic          chk_valid,
  input  logic [BW-1:0] chk_blk,
  output logic          chk_permit,
  output logic          chk_lock_err,
  input  logic [BW-1:0] stat_blk,
  output logic [1:0]    stat_bits
);
  logic               go;
  lk_op_e             op;
  logic [BW-1:0]      blk;
  logic [NUM_BLK-1:0] lk;
  logic [NUM_BLK-1:0] dn;
  logic [1:0]         chk_bits;

  assign cmd_ready = 1'b1;

  blkprot_seq #(.NUM_BLK(NUM_BLK), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_blk(cmd_blk), .go(go), .op(op), .blk(blk)
  );

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_cell
    blkprot_cell u_cell (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
      .hit(go && (blk == BW'(g))), .op(op),
      .locked(lk[g]), .down(dn[g])
    );
  end

  blkprot_port #(.NUM_BLK(NUM_BLK), .BW(BW)) u_stat (
    .lk(lk), .dn(dn), .idx(stat_blk), .bits(stat_bits)
  );

  blkprot_port #(.NUM_BLK(NUM_BLK), .BW(BW)) u_chk (
    .lk(lk), .dn(dn), .idx(chk_blk), .bits(chk_bits)
  );

  assign chk_permit   = !chk_bits[0];
  assign chk_lock_err = chk_valid && chk_bits[0];
endmodule

// File: rtl/blkprot_mgr_chk.sv
module blkprot_mgr_chk
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp_n,
  input logic               chk_valid,
  input logic               chk_permit,
  input logic               chk_lock_err,
  input logic               go,
  input lk_op_e             op,
  input logic [BW-1:0]      blk,
  input logic [NUM_BLK-1:0] lk,
  input logic [NUM_BLK-1:0] dn
);
  // R8: an error flag needs a qualified request, and a permitted request raises no error
  assert_err_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lock_err |-> chk_valid);
  assert_permit_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_permit) |-> !chk_lock_err);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_prop
    // R7: the lock-down mark never drops outside reset
    assert_mark_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(dn[g]));
    // R4: a marked, locked block stays locked while the pin is low
    assert_down_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && dn[g] && lk[g]) |=> lk[g]);
    // R2: an accepted lock or lock-down leaves the block locked
    assert_lock_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && blk == BW'(g) && (op == OP_LOCK || op == OP_DOWN)) |=> lk[g]);
  end
endmodule

bind blkprot_mgr blkprot_mgr_chk #(.NUM_BLK(NUM_BLK), .BW(BW)) u_prop (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .chk_valid(chk_valid),
  .chk_permit(chk_permit), .chk_lock_err(chk_lock_err),
  .go(go), .op(op), .blk(blk), .lk(lk), .dn(dn)
);

// File: tb/blkprot_mgr_test.sv
module blkprot_mgr_test;
  localparam int NB = 6;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_code = 8'h00;
  logic [BW-1:0] cmd_blk = '0;
  logic          chk_valid = 1'b0;
  logic [BW-1:0] chk_blk = '0;
  logic          chk_permit;
  logic          chk_lock_err;
  logic [BW-1:0] stat_blk = '0;
  logic [1:0]    stat_bits;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] m [NB];

  always #10 clk = ~clk;

  blkprot_mgr #(.NUM_BLK(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_blk(cmd_blk),
    .chk_valid(chk_valid), .chk_blk(chk_blk), .chk_permit(chk_permit),
    .chk_lock_err(chk_lock_err), .stat_blk(stat_blk), .stat_bits(stat_bits)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [BW-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_blk = b;
    #1 check("R10 ready", {3'b0, cmd_ready}, 4'h1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stat_is(input string req, input logic [BW-1:0] b, input logic [1:0] exp);
    stat_blk = b;
    #1 check(req, {2'b0, stat_bits}, {2'b0, exp});
  endtask

  task automatic all_match(input string req);
    for (int i = 0; i < NB; i++) stat_is(req, BW'(i), m[i]);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) m[i] = 2'b01;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; #1
    stat_is("R1 in reset", 0, 2'b01);
    idle(2); rst_n = 1'b1;
    for (int i = 0; i < NB; i++) m[i] = 2'b01;
    all_match("R1 after reset");
    chk_valid = 1'b1; chk_blk = 3'd4; #1
    check("R1 permit", {2'b0, chk_permit, chk_lock_err}, 4'b0001);
    chk_valid = 1'b0;
  endtask

  task automatic t_basic;
    send(8'h60, 0); send(8'hD0, 0); m[0] = 2'b00;
    stat_is("R2 unlock", 0, 2'b00);
    send(8'h60, 0); send(8'h01, 0); m[0] = 2'b01;
    stat_is("R2 lock", 0, 2'b01);
    send(8'h60, 1); send(8'h2F, 1); m[1] = 2'b11;
    stat_is("R2 lockdown", 1, 2'b11);
    all_match("R11 basic");
  endtask

  task automatic t_sequence;
    send(8'hD0, 2);
    stat_is("R3 no setup", 2, 2'b01);
    send(8'h60, 2); send(8'hFF, 2); send(8'hD0, 2);
    stat_is("R3 cancelled", 2, 2'b01);
    send(8'h60, 2); idle(3); send(8'hD0, 2); m[2] = 2'b00;
    stat_is("R3 idle gap", 2, 2'b00);
    send(8'h60, 3); send(8'h60, 3); send(8'hD0, 3); m[3] = 2'b00;
    stat_is("R3 double setup", 3, 2'b00);
    all_match("R11 sequence");
  endtask

  task automatic t_wp_low;
    wp_n = 1'b0;
    send(8'h60, 1); send(8'hD0, 1);
    stat_is("R4 refused", 1, 2'b11);
  endtask

  task automatic t_wp_high;
    wp_n = 1'b1;
    send(8'h60, 1); send(8'hD0, 1); m[1] = 2'b10;
    stat_is("R5 unlock", 1, 2'b10);
    send(8'h60, 1); send(8'h01, 1);
    stat_is("R5 relock", 1, 2'b11);
    send(8'h60, 1); send(8'hD0, 1);
    stat_is("R7 mark kept", 1, 2'b10);
  endtask

  task automatic t_wp_return;
    @(negedge clk); wp_n = 1'b0;
    stat_is("R6 still unlocked", 1, 2'b10);
    send(8'h60, 1); send(8'h01, 1); m[1] = 2'b11;
    stat_is("R6 relock", 1, 2'b11);
    send(8'h60, 1); send(8'hD0, 1);
    stat_is("R6 refused", 1, 2'b11);
    all_match("R11 wp");
  endtask

  task automatic t_range;
    send(8'h60, 6); send(8'hD0, 6);
    send(8'h60, 7); send(8'h2F, 7);
    stat_is("R9 read 6", 6, 2'b01);
    stat_is("R9 read 7", 7, 2'b01);
    chk_valid = 1'b1; chk_blk = 3'd7; #1
    check("R9 permit", {2'b0, chk_permit, chk_lock_err}, 4'b0001);
    chk_valid = 1'b0;
    all_match("R9 no alias");
  endtask

  task automatic t_permit;
    chk_valid = 1'b1; chk_blk = 3'd2; #1
    check("R8 open", {2'b0, chk_permit, chk_lock_err}, 4'b0010);
    chk_blk = 3'd0; #1
    check("R8 locked", {2'b0, chk_permit, chk_lock_err}, 4'b0001);
    chk_valid = 1'b0; #1
    check("R8 no request", {2'b0, chk_permit, chk_lock_err}, 4'b0000);
    send(8'h60, 0); send(8'hD0, 0); m[0] = 2'b00;
    chk_valid = 1'b1; #1
    check("R8 follows unlock", {2'b0, chk_permit, chk_lock_err}, 4'b0010);
    chk_valid = 1'b0;
  endtask

  task automatic t_reset_clears;
    do_reset();
    all_match("R7 reset clears mark");
    wp_n = 1'b0;
    send(8'h60, 1); send(8'hD0, 1); m[1] = 2'b00;
    stat_is("R7 unlock after reset", 1, 2'b00);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    idle(200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_sequence();
    t_wp_low();
    t_wp_high();
    t_wp_return();
    t_range();
    t_permit();
    t_reset_clears();
    finish_run();
  end
endmodule